// File: doc/BRIEF.md
# Interrupt Mask and Bus-Cycle Watchdog

This block sits between the interrupt sources of a system built around a processor with seven interrupt priority levels and the processor's three interrupt-level inputs. Requests come from on-board devices, from expansion-bus cards, from an expansion-bus power-fail line, and from software itself. The block keeps a software-written enable mask and a read-only view of the raw requests. It presents the encoded number of the most urgent enabled request to the processor.

When the processor acknowledges an interrupt, the block answers in one of two ways. Most levels are answered with an autovector request. For the levels whose devices supply their own vector, the acknowledge is passed on to a per-level external line. Separately, a watchdog times every bus cycle from the rise of address strobe. It flags a bus error if no data acknowledge arrives within the limit, which is 16 microseconds by default.

Top module: `irqc_top`

## Requirements
- R1: The mask register (select 0) has bit n enable level n for n = 1..7, and bit 0 reads 0. It resets to all zero. A level whose mask bit is 0 never appears on `cpu_ipl`, and with the mask at zero `cpu_ipl` stays 0.
- R2: `cpu_ipl` carries the binary number of the highest level that is both pending and enabled, or 0 if there is none. It is registered, so it reflects inputs and register contents one clock edge later.
- R3: The status register (select 1) reads the raw pending state of levels 1..7 in bits 1..7, before masking. Bit 0 reads 0.
- R4: A write to the software-interrupt register (select 2) with nonzero data raises a level-1 request, and a write of zero removes it. The register reads the request in bit 0.
- R5: `pwr_fail` raises a level-7 request, in addition to `dev_irq[7]` from expansion cards.
- R6: During an acknowledge cycle (`bus_as` high and `bus_fc` = 3'b111), the level on `bus_ack_lvl` selects the response. For levels 5 and 6, `ext_iack[level]` is asserted. For any other level, `vpa` is asserted. The response appears one edge after the cycle is first sampled and is removed one edge after `bus_as` falls.
- R7: When `bus_fc` is not 3'b111, neither `vpa` nor any `ext_iack` bit is asserted.
- R8: If `bus_dtack` stays low, `bus_err` rises exactly 256 clock edges (16 ticks × 16 clocks) after the edge that first samples `bus_as` high. It stays low on the edge before that.
- R9: A `bus_dtack` that arrives before the limit prevents `bus_err` for that cycle. `bus_err` falls on the first edge that samples `bus_as` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 per microsecond by default) |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 mask, 1 status, 2 software interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dev_irq | input | 7 | Raw requests, bit n = level n (indices 7:1) |
| pwr_fail | input | 1 | Expansion-bus power-fail, raises level 7 |
| cpu_ipl | output | 3 | Encoded interrupt level to the processor |
| bus_as | input | 1 | Address strobe, active high |
| bus_fc | input | 3 | Processor function code |
| bus_ack_lvl | input | 3 | Level being acknowledged |
| bus_dtack | input | 1 | Data acknowledge, active high |
| vpa | output | 1 | Autovector request |
| ext_iack | output | 7 | Per-level external acknowledge (indices 7:1) |
| bus_err | output | 1 | Bus error from the cycle watchdog |

## Verification
Each output is due a known number of edges after its stimulus. `cpu_ipl` is due one edge after a request or a mask change, which means two edges after a register write strobe is presented. The acknowledge response is due one edge after strobe and function code appear, and it is gone one edge after the strobe drops. `bus_err` is due exactly 256 edges after the first strobe sample. Inputs change on falling edges and outputs are read on the falling edge that follows the edge in question. The timeout is therefore checked on both the 255th and the 256th edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned LVL_W   = 3;
   localparam int unsigned NUM_LVL = (1 << LVL_W) - 1;
   localparam int unsigned SEL_W   = 2;
   localparam int unsigned DATA_W  = NUM_LVL + 1;

   typedef enum logic [SEL_W-1:0] {
      SEL_MASK   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_SWI    = 2'd2
   } reg_sel_e;

   localparam logic [2:0] FC_ACK = 3'b111;
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
   parameter int unsigned LVL_W   = 3,
   parameter int unsigned NUM_LVL = 7
) (
   input  logic [NUM_LVL:1]  req,
   output logic [LVL_W-1:0]  lvl
);
   if (NUM_LVL != (1 << LVL_W) - 1) begin : g_bad_cfg
      $error("irqc_prio_enc: NUM_LVL must equal 2**LVL_W-1");
   end

   always_comb begin
      lvl = '0;
      for (int i = 1; i <= NUM_LVL; i++) begin
         if (req[i]) lvl = LVL_W'(i);
      end
   end
endmodule

// File: rtl/irqc_ack_steer.sv
module irqc_ack_steer #(
   parameter int unsigned LVL_W    = 3,
   parameter int unsigned NUM_LVL  = 7,
   parameter int unsigned VEC_MASK = 32'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_i,
   input  logic [2:0]        fc_i,
   input  logic [LVL_W-1:0]  lvl_i,
   output logic              vpa_o,
   output logic [NUM_LVL:1]  ext_o
);
   import irqc_pkg::*;

   if (VEC_MASK[0] != 1'b0) begin : g_bad_mask
      $error("irqc_ack_steer: level 0 cannot be vectored");
   end

   logic              ack_cyc;
   logic [NUM_LVL:1]  ext_d;
   logic              is_vec;

   assign ack_cyc = as_i && (fc_i == FC_ACK);

   for (genvar g = 1; g <= NUM_LVL; g++) begin : g_lvl
      if (VEC_MASK[g]) begin : g_vec
         assign ext_d[g] = ack_cyc && (lvl_i == LVL_W'(g));
      end else begin : g_auto
         assign ext_d[g] = 1'b0;
      end
   end

   assign is_vec = |ext_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpa_o <= 1'b0;
         ext_o <= '0;
      end else begin
         vpa_o <= ack_cyc && !is_vec;
         ext_o <= ext_d;
      end
   end

   // R6
   ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vpa_o, ext_o}));

   // R7
   no_ack_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!as_i || fc_i != FC_ACK) |=> (!vpa_o && ext_o == '0));
endmodule

// File: rtl/irqc_bus_wdog.sv
module irqc_bus_wdog #(
   parameter int unsigned CLK_PER_TICK = 16,
   parameter int unsigned LIMIT_TICKS  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic as_i,
   input  logic dtack_i,
   output logic err_o
);
   localparam int unsigned PRE_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
   localparam int unsigned CNT_W = $clog2(LIMIT_TICKS + 1);

   if (CLK_PER_TICK < 2) begin : g_bad_pre
      $error("irqc_bus_wdog: CLK_PER_TICK must be at least 2");
   end
   if (LIMIT_TICKS < 1) begin : g_bad_lim
      $error("irqc_bus_wdog: LIMIT_TICKS must be at least 1");
   end

   logic              as_q;
   logic [PRE_W-1:0]  pre_q;
   logic [CNT_W-1:0]  tick_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         as_q   <= 1'b0;
         pre_q  <= '0;
         tick_q <= '0;
         err_o  <= 1'b0;
      end else begin
         as_q <= as_i;
         if (!as_i || !as_q) begin
            pre_q  <= '0;
            tick_q <= '0;
            err_o  <= 1'b0;
         end else if (!dtack_i && !err_o) begin
            if (pre_q == PRE_W'(CLK_PER_TICK - 1)) begin
               pre_q <= '0;
               if (tick_q == CNT_W'(LIMIT_TICKS - 1)) err_o <= 1'b1;
               else tick_q <= tick_q + 1'b1;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end
      end
   end

   // R8
   err_needs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(as_i && !dtack_i));

   // R9
   err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(as_i) |=> !err_o);
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
   parameter int unsigned VEC_MASK     = 32'h60,
   parameter int unsigned SW_LVL       = 1,
   parameter int unsigned PF_LVL       = 7,
   parameter int unsigned CLK_PER_US   = 16,
   parameter int unsigned TIMEOUT_US   = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  reg_sel,
   input  logic        reg_wr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic [7:1]  dev_irq,
   input  logic        pwr_fail,
   output logic [2:0]  cpu_ipl,
   input  logic        bus_as,
   input  logic [2:0]  bus_fc,
   input  logic [2:0]  bus_ack_lvl,
   input  logic        bus_dtack,
   output logic        vpa,
   output logic [7:1]  ext_iack,
   output logic        bus_err
);
   import irqc_pkg::*;

   if (SW_LVL < 1 || SW_LVL > NUM_LVL) begin : g_bad_sw
      $error("irqc_top: SW_LVL out of range");
   end
   if (PF_LVL < 1 || PF_LVL > NUM_LVL) begin : g_bad_pf
      $error("irqc_top: PF_LVL out of range");
   end
   if (VEC_MASK[SW_LVL] != 1'b0) begin : g_bad_swvec
      $error("irqc_top: software level must be autovectored");
   end

   logic [NUM_LVL:1]  mask_q;
   logic              sw_q;
   logic [NUM_LVL:1]  raw;
   logic [NUM_LVL:1]  live;
   logic [LVL_W-1:0]  enc_lvl;

   for (genvar g = 1; g <= NUM_LVL; g++) begin : g_raw
      assign raw[g] = dev_irq[g]
                    | ((g == PF_LVL) ? pwr_fail : 1'b0)
                    | ((g == SW_LVL) ? sw_q     : 1'b0);
   end

   assign live = raw & mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         sw_q   <= 1'b0;
      end else if (reg_wr) begin
         case (reg_sel)
            SEL_MASK: mask_q <= reg_wdata[NUM_LVL:1];
            SEL_SWI:  sw_q   <= |reg_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_sel)
         SEL_MASK:   reg_rdata = {mask_q, 1'b0};
         SEL_STATUS: reg_rdata = {raw, 1'b0};
         SEL_SWI:    reg_rdata = {{(DATA_W-1){1'b0}}, sw_q};
         default:    reg_rdata = '0;
      endcase
   end

   irqc_prio_enc #(.LVL_W(LVL_W), .NUM_LVL(NUM_LVL)) u_enc (
      .req (live),
      .lvl (enc_lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) cpu_ipl <= '0;
      else        cpu_ipl <= enc_lvl;
   end

   irqc_ack_steer #(.LVL_W(LVL_W), .NUM_LVL(NUM_LVL), .VEC_MASK(VEC_MASK)) u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .as_i  (bus_as),
      .fc_i  (bus_fc),
      .lvl_i (bus_ack_lvl),
      .vpa_o (vpa),
      .ext_o (ext_iack)
   );

   irqc_bus_wdog #(.CLK_PER_TICK(CLK_PER_US), .LIMIT_TICKS(TIMEOUT_US)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .as_i    (bus_as),
      .dtack_i (bus_dtack),
      .err_o   (bus_err)
   );

   // R1
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |=> (cpu_ipl == '0));

   // R4
   swi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_SWI && reg_wdata != '0) |=> raw[SW_LVL]);

   // R5
   pf_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |-> raw[PF_LVL]);
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:1] dev_irq = '0;
   logic       pwr_fail = 1'b0;
   logic [2:0] cpu_ipl;
   logic       bus_as = 1'b0;
   logic [2:0] bus_fc = '0;
   logic [2:0] bus_ack_lvl = '0;
   logic       bus_dtack = 1'b0;
   logic       vpa;
   logic [7:1] ext_iack;
   logic       bus_err;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irqc_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_irq(dev_irq),
      .pwr_fail(pwr_fail), .cpu_ipl(cpu_ipl), .bus_as(bus_as), .bus_fc(bus_fc),
      .bus_ack_lvl(bus_ack_lvl), .bus_dtack(bus_dtack), .vpa(vpa),
      .ext_iack(ext_iack), .bus_err(bus_err)
   );

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [7:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(string req, logic [1:0] sel, logic [7:0] exp);
      reg_sel = sel;
      #1;
      check(req, 32'(reg_rdata), 32'(exp));
   endtask

   task automatic t_reset;
      check("R1 reset ipl", 32'(cpu_ipl), 0);
      check("R6 reset vpa", 32'(vpa), 0);
      check("R6 reset ext", 32'(ext_iack), 0);
      check("R8 reset err", 32'(bus_err), 0);
      rd_check("R1 reset mask", 2'd0, 8'h00);
   endtask

   task automatic t_mask_prio;
      dev_irq = 7'b0010100;              // levels 3 and 5
      tick();
      check("R1 all masked", 32'(cpu_ipl), 0);
      wr(2'd0, 8'b0000_1000);            // enable level 3
      tick();
      check("R1 only level 3", 32'(cpu_ipl), 3);
      rd_check("R1 mask readback", 2'd0, 8'h08);
      wr(2'd0, 8'hFE);
      tick();
      check("R2 highest is 5", 32'(cpu_ipl), 5);
      dev_irq[6] = 1'b1;
      tick();
      check("R2 highest is 6", 32'(cpu_ipl), 6);
      dev_irq = '0;
      tick();
      check("R2 none pending", 32'(cpu_ipl), 0);
   endtask

   task automatic t_status;
      wr(2'd0, 8'h00);
      dev_irq = 7'b1000010;              // levels 2 and 7
      tick();
      rd_check("R3 raw status", 2'd1, 8'b1000_0100);
      check("R1 masked hidden", 32'(cpu_ipl), 0);
      dev_irq = '0;
      tick();
   endtask

   task automatic t_swi;
      wr(2'd0, 8'hFE);
      wr(2'd2, 8'h80);
      rd_check("R4 swi readback", 2'd2, 8'h01);
      rd_check("R4 swi in status", 2'd1, 8'h02);
      tick();
      check("R4 swi level 1", 32'(cpu_ipl), 1);
      wr(2'd2, 8'h00);
      tick();
      check("R4 swi cleared", 32'(cpu_ipl), 0);
      rd_check("R4 swi read zero", 2'd2, 8'h00);
   endtask

   task automatic t_pfail;
      dev_irq = 7'b0100000;              // level 6
      pwr_fail = 1'b1;
      tick();
      check("R5 powerfail level 7", 32'(cpu_ipl), 7);
      rd_check("R5 status bit 7", 2'd1, 8'b1100_0000);
      wr(2'd0, 8'h7E);                   // disable level 7
      tick();
      check("R1 level7 masked", 32'(cpu_ipl), 6);
      pwr_fail = 1'b0; dev_irq = '0;
      wr(2'd0, 8'hFE);
      tick();
   endtask

   task automatic ack_cycle(string req, logic [2:0] fc, logic [2:0] lvl,
                            logic exp_vpa, logic [7:1] exp_ext);
      bus_fc = fc; bus_ack_lvl = lvl; bus_as = 1'b1; bus_dtack = 1'b0;
      tick();
      check({req, " vpa"}, 32'(vpa), 32'(exp_vpa));
      check({req, " ext"}, 32'(ext_iack), 32'(exp_ext));
      bus_as = 1'b0;
      tick();
      check({req, " vpa off"}, 32'(vpa), 0);
      check({req, " ext off"}, 32'(ext_iack), 0);
   endtask

   task automatic t_ack;
      ack_cycle("R6 level 3 auto",   3'b111, 3'd3, 1'b1, 7'b0000000);
      ack_cycle("R6 level 5 vector", 3'b111, 3'd5, 1'b0, 7'b0010000);
      ack_cycle("R6 level 6 vector", 3'b111, 3'd6, 1'b0, 7'b0100000);
      ack_cycle("R6 level 7 auto",   3'b111, 3'd7, 1'b1, 7'b0000000);
      ack_cycle("R7 fc 6 ignored",   3'b110, 3'd5, 1'b0, 7'b0000000);
      ack_cycle("R7 fc 5 ignored",   3'b101, 3'd3, 1'b0, 7'b0000000);
   endtask

   task automatic t_timeout;
      bus_fc = 3'b101; bus_as = 1'b1; bus_dtack = 1'b0;
      tick();                            // edge that first samples strobe
      tick(LIMIT - 1);
      check("R8 no error at 255", 32'(bus_err), 0);
      tick();
      check("R8 error at 256", 32'(bus_err), 1);
      tick(3);
      check("R8 error held", 32'(bus_err), 1);
      bus_as = 1'b0;
      tick();
      check("R9 error cleared", 32'(bus_err), 0);
   endtask

   task automatic t_dtack;
      bus_as = 1'b1;
      tick(100);
      bus_dtack = 1'b1;
      tick(LIMIT + 50);
      check("R9 dtack stops timer", 32'(bus_err), 0);
      bus_as = 1'b0; bus_dtack = 1'b0;
      tick();
      bus_as = 1'b1;                     // new cycle restarts count
      tick(LIMIT);
      check("R8 restart counts full", 32'(bus_err), 0);
      tick();
      check("R8 restart expires", 32'(bus_err), 1);
      bus_as = 1'b0;
      tick();
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_mask_prio();
      t_status();
      t_swi();
      t_pfail();
      t_ack();
      t_timeout();
      t_dtack();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule